// File: doc/BRIEF.md
# Round-Robin Output Port Allocator

This block sits at one output port of a five-input wormhole router and decides which input may send through that output. Each input raises a request when the flit at the head of its FIFO is routed here. The allocator picks one requester by rotating priority and keeps that choice for the whole packet, from the header flit to the tail flit. While it holds a grant, the allocator drives the crossbar multiplexer select for this output and the read strobe of the winning input FIFO.

A flit moves in a cycle only when the winning FIFO is non-empty and the downstream stage is ready. The read strobe is also the transfer strobe. When the tail flit moves, the grant drops in the next cycle. The served input then becomes the lowest-priority input. The next arbitration happens in the idle cycle that follows, so there is always one cycle without a grant between two packets.

Top module: `out_alloc`

## Requirements
- R1: After reset, `grant_o`, `fifo_rd_o` and `out_valid_o` are all zero and `sel_o` is 0.
- R2: When no grant is held and at least one input requests, the requester with the highest current priority is granted in the next cycle, and no other input is granted. After reset, input 0 has the highest priority, followed by inputs 1, 2, 3 and 4.
- R3: When a packet from input k completes, priority rotates. Input k+1 (wrapping from 4 to 0) becomes highest and input k becomes lowest.
- R4: A grant is one-hot and stays unchanged from the header flit until the tail flit is read. Requests from other inputs during a packet have no effect on it.
- R5: While a grant is held, `sel_o` carries the 3-bit binary index of the granted input. While idle, `sel_o` is 0.
- R6: `fifo_rd_o` has at most one bit set, and only the bit of the granted input. That bit is set exactly in cycles where `out_ready_i` is high and the granted input's FIFO is non-empty.
- R7: `out_valid_o` is low while no grant is held. While a grant is held, it equals the granted input's non-empty flag.
- R8: An input that keeps requesting is granted before more than 4 grants go to other inputs.
- R9: In the cycle after the tail flit is read (read strobe high together with that input's tail flag), `grant_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 5 | Per-input request for this output |
| fifo_nempty_i | input | 5 | Per-input FIFO non-empty flag |
| flit_tail_i | input | 5 | Per-input flag: head flit of the FIFO is a tail |
| out_ready_i | input | 1 | Downstream can accept a flit this cycle |
| grant_o | output | 5 | One-hot grant, held for a packet |
| sel_o | output | 3 | Crossbar multiplexer select (input index) |
| fifo_rd_o | output | 5 | Per-input FIFO read strobe |
| out_valid_o | output | 1 | A flit is presented on this output |

## Verification
The bench checks the order of grants when all five inputs contend at once. A design whose priority does not rotate would serve the same low index again, and a design that rotates by the wrong amount would serve the wrong successor. A second input requests in the middle of a long packet, so a design that re-arbitrates before the tail would hand over the output mid-packet. Downstream ready is toggled and the owner's FIFO is stalled, which exposes a read strobe that ignores back-pressure or emptiness, and a valid that stays high with nothing to send. Every new grant is checked against the wait counts of the other requesters, so an arbiter that starves an input breaks the bound of four other grants.

// File: rtl/out_alloc_pkg.sv
package out_alloc_pkg;
  typedef enum logic {
    ALLOC_IDLE = 1'b0,
    ALLOC_HOLD = 1'b1
  } alloc_state_e;
endpackage

// File: rtl/out_alloc_rr_pick.sv
// Rotating-priority pick: ptr_i is the highest-priority index.
module out_alloc_rr_pick #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o
);
  localparam logic [IW:0] N_W = (IW+1)'(N);

  logic [IW:0] idx;
  logic        found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = {1'b0, ptr_i} + (IW+1)'(k);
      if (idx >= N_W) idx = idx - N_W;
      if (!found && req_i[idx[IW-1:0]]) begin
        gnt_o[idx[IW-1:0]] = 1'b1;
        found = 1'b1;
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/out_alloc_oh2idx.sv
module out_alloc_oh2idx #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  oh_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_i[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/out_alloc_ctrl.sv
// Grant lock and priority pointer.
module out_alloc_ctrl
  import out_alloc_pkg::*;
#(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pick_gnt_i,
  input  logic          pick_any_i,
  input  logic          own_last_i,
  output logic          hold_o,
  output logic [N-1:0]  owner_oh_o,
  output logic [IW-1:0] owner_idx_o,
  output logic [IW-1:0] ptr_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N-1);

  alloc_state_e  state_q;
  logic [N-1:0]  owner_oh_q;
  logic [IW-1:0] owner_idx_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick_idx;

  out_alloc_oh2idx #(.N(N), .IW(IW)) i_enc (
    .oh_i  (pick_gnt_i),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ALLOC_IDLE;
      owner_oh_q  <= '0;
      owner_idx_q <= '0;
      ptr_q       <= '0;
    end else begin
      unique case (state_q)
        ALLOC_IDLE: begin
          if (pick_any_i) begin
            state_q     <= ALLOC_HOLD;
            owner_oh_q  <= pick_gnt_i;
            owner_idx_q <= pick_idx;
          end
        end
        ALLOC_HOLD: begin
          if (own_last_i) begin
            state_q     <= ALLOC_IDLE;
            owner_oh_q  <= '0;
            owner_idx_q <= '0;
            // served input drops to lowest priority
            ptr_q       <= (owner_idx_q == LAST_IDX) ? '0 : owner_idx_q + 1'b1;
          end
        end
        default: state_q <= ALLOC_IDLE;
      endcase
    end
  end

  assign hold_o      = (state_q == ALLOC_HOLD);
  assign owner_oh_o  = owner_oh_q;
  assign owner_idx_o = owner_idx_q;
  assign ptr_o       = ptr_q;
endmodule

// File: rtl/out_alloc.sv
module out_alloc #(
  parameter int unsigned N_IN  = 5,
  parameter int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  req_i,
  input  logic [N_IN-1:0]  fifo_nempty_i,
  input  logic [N_IN-1:0]  flit_tail_i,
  input  logic             out_ready_i,
  output logic [N_IN-1:0]  grant_o,
  output logic [IDX_W-1:0] sel_o,
  output logic [N_IN-1:0]  fifo_rd_o,
  output logic             out_valid_o
);
  logic [N_IN-1:0]  pick_gnt;
  logic             pick_any;
  logic             hold;
  logic [N_IN-1:0]  owner_oh;
  logic [IDX_W-1:0] owner_idx;
  logic [IDX_W-1:0] ptr;
  logic             own_nempty;
  logic             own_tail;
  logic             xfer;

  out_alloc_rr_pick #(.N(N_IN), .IW(IDX_W)) i_pick (
    .req_i (req_i),
    .ptr_i (ptr),
    .gnt_o (pick_gnt),
    .any_o (pick_any)
  );

  out_alloc_ctrl #(.N(N_IN), .IW(IDX_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pick_gnt_i  (pick_gnt),
    .pick_any_i  (pick_any),
    .own_last_i  (xfer & own_tail),
    .hold_o      (hold),
    .owner_oh_o  (owner_oh),
    .owner_idx_o (owner_idx),
    .ptr_o       (ptr)
  );

  assign own_nempty = |(owner_oh & fifo_nempty_i);
  assign own_tail   = |(owner_oh & flit_tail_i);
  assign xfer       = hold & own_nempty & out_ready_i;

  for (genvar g = 0; g < N_IN; g++) begin : g_rd
    assign fifo_rd_o[g] = owner_oh[g] & xfer;
  end

  assign grant_o     = owner_oh;
  assign sel_o       = owner_idx;
  assign out_valid_o = hold & own_nempty;
endmodule

// File: rtl/out_alloc_chk.sv
module out_alloc_chk #(
  parameter int unsigned N_IN  = 5,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IN-1:0]  req_i,
  input logic [N_IN-1:0]  fifo_nempty_i,
  input logic [N_IN-1:0]  flit_tail_i,
  input logic             out_ready_i,
  input logic [N_IN-1:0]  grant_o,
  input logic [IDX_W-1:0] sel_o,
  input logic [N_IN-1:0]  fifo_rd_o,
  input logic             out_valid_o
);
  logic [N_IN-1:0] prev_gnt_q;
  logic [3:0]      wait_q [N_IN];
  logic            new_gnt;

  assign new_gnt = (grant_o != '0) && (prev_gnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_gnt_q <= '0;
    else         prev_gnt_q <= grant_o;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_fair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_q[g] <= '0;
      else if (!req_i[g] || grant_o[g]) wait_q[g] <= '0;
      else if (new_gnt && wait_q[g] != 4'hf) wait_q[g] <= wait_q[g] + 1'b1;
    end

    p_fair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q[g] <= 4'(N_IN - 1));
  end

  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) && ((fifo_rd_o & flit_tail_i) == '0) |=> grant_o == $past(grant_o));

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fifo_rd_o & flit_tail_i) != '0) |=> grant_o == '0);

  p_win_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) && (req_i != '0) |=> (grant_o & $past(req_i)) != '0);

  p_rd_owner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_o & ~grant_o) == '0);

  p_rd_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_o != '0) |-> out_ready_i && ((fifo_rd_o & fifo_nempty_i) != '0));

  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |-> !out_valid_o);

  p_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> grant_o[sel_o]);
endmodule

bind out_alloc out_alloc_chk #(.N_IN(N_IN), .IDX_W(IDX_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .fifo_nempty_i (fifo_nempty_i),
  .flit_tail_i   (flit_tail_i),
  .out_ready_i   (out_ready_i),
  .grant_o       (grant_o),
  .sel_o         (sel_o),
  .fifo_rd_o     (fifo_rd_o),
  .out_valid_o   (out_valid_o)
);

// File: tb/test_out_alloc.sv
`timescale 1ns/1ps
module test_out_alloc;
  localparam int N = 5;
  localparam time T_CLK = 8ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, nempty = '0, tail = '0;
  logic         rdy = 1'b1;
  logic [N-1:0] grant, rd;
  logic [2:0]   sel;
  logic         valid;

  int errors = 0, checks = 0;
  int rem [N];
  bit stall [N];
  int wcnt [N];
  int exp_q [$];
  logic [N-1:0] pend_rd = '0, prev_g = '0, prev_req = '0;
  logic         prev_last = 1'b0;
  bit           done = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  out_alloc i_out_alloc (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .fifo_nempty_i(nempty),
    .flit_tail_i(tail), .out_ready_i(rdy), .grant_o(grant), .sel_o(sel),
    .fifo_rd_o(rd), .out_valid_o(valid)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      req[i]    = rem[i] > 0;
      nempty[i] = (rem[i] > 0) && !stall[i];
      tail[i]   = rem[i] == 1;
    end
  endtask

  // monitor: compares outputs against expectations each cycle
  task automatic monitor();
    logic [N-1:0] exp_rd;
    if (grant != '0 && prev_g == '0) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected grant", grant, 0);
      end else begin
        int e = exp_q.pop_front();
        chk(grant == N'(1 << e), "R2/R3 grant order", grant, 1 << e);
        chk(sel == 3'(e), "R5 select index", sel, e);
        for (int i = 0; i < N; i++) begin
          if (i == e) wcnt[i] = 0;
          else if (prev_req[i]) wcnt[i]++;
          chk(wcnt[i] <= 4, "R8 fairness bound", wcnt[i], 4);
        end
      end
    end
    for (int i = 0; i < N; i++) if (!req[i]) wcnt[i] = 0;
    if (prev_g != '0 && grant != prev_g)
      chk(prev_last, "R4 grant changed mid-packet", grant, prev_g);
    if (prev_last) chk(grant == '0, "R9 release after tail", grant, 0);
    if (prev_g == '0 && prev_req != '0)
      chk(grant != '0, "R2 grant one cycle after request", grant, 1);
    exp_rd = (rdy && (grant & nempty) != '0) ? grant : '0;
    chk(rd == exp_rd, "R6 read strobe", rd, exp_rd);
    chk(valid == ((grant & nempty) != '0), "R7 output valid", valid, (grant & nempty) != '0);
    if (grant == '0) chk(sel == 3'd0, "R5 idle select", sel, 0);
    prev_g    = grant;
    prev_req  = req;
    prev_last = (rd & tail) != '0;
  endtask

  task automatic step();
    @(negedge clk);
    for (int i = 0; i < N; i++) if (pend_rd[i]) rem[i]--;
    drive();
    #1;
    pend_rd = rd;
    monitor();
  endtask

  task automatic send(input int in, input int len, input int exp_owner);
    rem[in] = len;
    exp_q.push_back(exp_owner);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    do begin
      step();
      n++;
    end while ((rem.sum() != 0 || grant != '0) && n < 500);
    chk(rem.sum() == 0, {tag, " all flits transferred"}, rem.sum(), 0);
    chk(exp_q.size() == 0, {tag, " all grants seen"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(T_CLK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin rem[i] = 0; stall[i] = 0; wcnt[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(grant == '0 && rd == '0 && !valid && sel == 0, "R1 reset state",
        {grant, rd, valid, sel}, 0);
    @(negedge clk) rst_n = 1'b1;

    // single requester; input 0 highest after reset but only 2 asks
    send(2, 3, 2);
    drain("R2 single");

    // all five contend; pointer now 3
    for (int i = 0; i < N; i++) rem[i] = 2;
    exp_q = '{3, 4, 0, 1, 2};
    drain("R3 rotate all");

    // long packet from 0 with back-pressure; 1 requests mid-packet
    send(0, 6, 0);
    for (int c = 0; c < 4; c++) begin rdy = (c % 2 == 0); step(); end
    send(1, 2, 1);
    for (int c = 0; c < 6; c++) begin rdy = (c % 3 != 0); step(); end
    rdy = 1'b1;
    drain("R4 lock");

    // pointer 2: 4 beats 1; stall owner 4 for a while
    send(1, 3, 4);
    send(4, 3, 1);
    exp_q = '{4, 1};
    step(); step();
    stall[4] = 1;
    step(); step(); step();
    chk(!valid && rd == '0, "R7 stalled owner no valid", {valid, rd}, 0);
    stall[4] = 0;
    drain("R6 stall");

    // pointer 2 again: staggered contention, 0 requesting throughout
    send(0, 3, 2);
    send(2, 1, 3);
    send(3, 2, 4);
    send(4, 1, 0);
    exp_q = '{2, 3, 4, 0};
    drain("R8 fairness");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule